// File: doc/BRIEF.md
# Six-Channel Measurement Status Latch

This block holds the measurement status of six correlator channels: a new-data flag, a missed-measurement flag and a slew flag per channel. Measurement data is offered at each TIC. A channel that still holds unread data is protected, so its TIC data is refused and the refusal is recorded as a missed measurement. The host releases a channel in one of two ways: it writes to the channel's clear location, or it finishes a read of the channel's carrier-cycle register.

The host does not see the live flags directly. It reads two 16-bit words that are snapshots of those flags. A snapshot is taken on a rising edge of either interrupt line, or when the host writes to a latch-request location. A read of the carrier-cycle register releases a channel only if the last snapshot showed that channel's data as new. Data that arrived after the snapshot therefore stays protected and appears at the next snapshot.

Three events clear everything, live flags and snapshots alike: a hardware reset, a software reset, or disabling clock-phase propagation.

Top module: `msl_status_latch`

## Requirements
- R1: While `rstN` is low, and after it rises until the first snapshot, `statusA` and `statusB` read 0x0000.
- R2: Word layout. `statusA` bit i (i = 0..5) is the new-data flag of channel i+1. `statusB` bit i is the missed flag of that channel and bit 8+i is its slew flag. All other bits read 0.
- R3: The words change only in the cycle after a trigger. A trigger is one of three things: `intOut` low in one cycle and high in the next, the same for `intIn`, or `latchWr` high. The words then show the live flags as they stood before that clock edge's own updates. A level held high does not trigger again.
- R4: A `tic` cycle with `dataRdy[i]` high, while channel i's new-data flag is clear, sets that flag.
- R5: `chanClrWr[i]` clears channel i's new-data, missed and slew flags. It overrides a `tic` in the same cycle.
- R6: A read ends when `carrRd[i]` is high in one cycle and low in the next. The end of a read clears channel i's new-data flag only if the current snapshot shows that flag set. Accepting TIC data in the same cycle overrides this clear.
- R7: A `tic` with `dataRdy[i]` high while channel i's new-data flag is set leaves the flag set and sets the missed flag. The missed flag stays set until a clear write or a flush.
- R8: On each `tic` while channel i's new-data flag is clear, the slew flag takes `slewIn[i]`. While the channel is protected, the slew flag holds its value.
- R9: `swReset` high, or `phaseEn` low, clears all live flags and both words by the next cycle. `rstN` low clears them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| swReset | input | 1 | Software master reset, synchronous |
| phaseEn | input | 1 | Clock-phase propagation enable; low clears all flags |
| intOut | input | 1 | Interrupt line; a rising edge takes a snapshot |
| intIn | input | 1 | Second interrupt line; a rising edge takes a snapshot |
| latchWr | input | 1 | Host write to the latch-request location |
| chanClrWr | input | 6 | Per-channel clear write strobes |
| carrRd | input | 6 | Per-channel carrier-cycle read strobes (level) |
| tic | input | 1 | Measurement TIC pulse |
| dataRdy | input | 6 | Per-channel measurement data offered at the TIC |
| slewIn | input | 6 | Per-channel slewing indication at the TIC |
| statusA | output | 16 | Snapshot of the new-data flags |
| statusB | output | 16 | Snapshot of the missed and slew flags |

## Verification
TIC sequences are applied first with a partial ready mask and then with a full one. Mixing free and protected channels separates data acceptance from missed-data recording, and shows whether the slew flag freezes on protected channels. A read that follows a snapshot taken before the data arrived separates a genuine release from the defeated one. Clear writes that land on a TIC check that the clear wins. Held interrupt levels and the two interrupt lines taken one at a time tell edge triggering apart from level triggering.

// File: rtl/msl_pkg.sv
package msl_pkg;
  parameter int unsigned MSL_CH        = 6;
  parameter int unsigned MSL_WORD      = 16;
  parameter int unsigned MSL_SLEW_BASE = 8;

  // Strobes the control side hands to the flag datapath each cycle.
  typedef struct packed {
    logic              flush;
    logic              snap;
    logic              tic;
    logic [MSL_CH-1:0] rdEnd;
    logic [MSL_CH-1:0] clr;
  } msl_strobe_t;
endpackage

// File: rtl/msl_ctrl.sv
module msl_ctrl
  import msl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              phaseEn,
  input  logic              intOut,
  input  logic              intIn,
  input  logic              latchWr,
  input  logic              tic,
  input  logic [MSL_CH-1:0] chanClrWr,
  input  logic [MSL_CH-1:0] carrRd,
  output msl_strobe_t       strobes
);
  logic              intOutQ;
  logic              intInQ;
  logic [MSL_CH-1:0] carrRdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intOutQ <= 1'b0;
      intInQ  <= 1'b0;
      carrRdQ <= '0;
    end else begin
      intOutQ <= intOut;
      intInQ  <= intIn;
      carrRdQ <= carrRd;
    end
  end

  always_comb begin
    strobes.flush = swReset | ~phaseEn;
    strobes.snap  = (intOut & ~intOutQ) | (intIn & ~intInQ) | latchWr;
    strobes.tic   = tic;
    strobes.rdEnd = carrRdQ & ~carrRd;
    strobes.clr   = chanClrWr;
  end
endmodule

// File: rtl/msl_dpath.sv
module msl_dpath
  import msl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  msl_strobe_t         strobes,
  input  logic [MSL_CH-1:0]   dataRdy,
  input  logic [MSL_CH-1:0]   slewIn,
  output logic [MSL_WORD-1:0] statusA,
  output logic [MSL_WORD-1:0] statusB
);
  logic [MSL_CH-1:0] liveNew, liveMiss, liveSlew;
  logic [MSL_CH-1:0] snapNew, snapMiss, snapSlew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveNew  <= '0;
      liveMiss <= '0;
      liveSlew <= '0;
      snapNew  <= '0;
      snapMiss <= '0;
      snapSlew <= '0;
    end else if (strobes.flush) begin
      liveNew  <= '0;
      liveMiss <= '0;
      liveSlew <= '0;
      snapNew  <= '0;
      snapMiss <= '0;
      snapSlew <= '0;
    end else begin
      if (strobes.snap) begin
        snapNew  <= liveNew;
        snapMiss <= liveMiss;
        snapSlew <= liveSlew;
      end
      for (int ch = 0; ch < MSL_CH; ch++) begin
        if (strobes.clr[ch]) begin
          liveNew[ch]  <= 1'b0;
          liveMiss[ch] <= 1'b0;
          liveSlew[ch] <= 1'b0;
        end else begin
          // New data is taken only while the channel is unprotected.
          if (strobes.tic && dataRdy[ch] && !liveNew[ch])
            liveNew[ch] <= 1'b1;
          else if (strobes.rdEnd[ch] && snapNew[ch])
            liveNew[ch] <= 1'b0;
          if (strobes.tic && dataRdy[ch] && liveNew[ch])
            liveMiss[ch] <= 1'b1;
          if (strobes.tic && !liveNew[ch])
            liveSlew[ch] <= slewIn[ch];
        end
      end
    end
  end

  always_comb begin
    statusA = '0;
    statusB = '0;
    statusA[MSL_CH-1:0]             = snapNew;
    statusB[MSL_CH-1:0]             = snapMiss;
    statusB[MSL_SLEW_BASE +: MSL_CH] = snapSlew;
  end
endmodule

// File: rtl/msl_status_latch.sv
module msl_status_latch
  import msl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReset,
  input  logic                phaseEn,
  input  logic                intOut,
  input  logic                intIn,
  input  logic                latchWr,
  input  logic [MSL_CH-1:0]   chanClrWr,
  input  logic [MSL_CH-1:0]   carrRd,
  input  logic                tic,
  input  logic [MSL_CH-1:0]   dataRdy,
  input  logic [MSL_CH-1:0]   slewIn,
  output logic [MSL_WORD-1:0] statusA,
  output logic [MSL_WORD-1:0] statusB
);
  msl_strobe_t strobes;

  msl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .phaseEn(phaseEn),
    .intOut(intOut), .intIn(intIn), .latchWr(latchWr), .tic(tic),
    .chanClrWr(chanClrWr), .carrRd(carrRd), .strobes(strobes)
  );

  msl_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataRdy(dataRdy),
    .slewIn(slewIn), .statusA(statusA), .statusB(statusB)
  );
endmodule

// File: rtl/msl_status_latch_chk.sv
module msl_status_latch_chk
  import msl_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                swReset,
  input logic                phaseEn,
  input logic                intOut,
  input logic                intIn,
  input logic                latchWr,
  input logic [MSL_CH-1:0]   chanClrWr,
  input logic [MSL_CH-1:0]   carrRd,
  input logic                tic,
  input logic [MSL_CH-1:0]   dataRdy,
  input logic [MSL_CH-1:0]   slewIn,
  input logic [MSL_WORD-1:0] statusA,
  input logic [MSL_WORD-1:0] statusB
);
  logic flushC;
  assign flushC = swReset || !phaseEn;

  // R9: a flush empties both words by the next cycle
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushC |=> (statusA == '0 && statusB == '0));

  // R3: the words hold when there is no trigger and no flush
  p_hold_untriggered_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!latchWr && !(intOut && !$past(intOut)) && !(intIn && !$past(intIn)) && !flushC)
    |=> ($stable(statusA) && $stable(statusB)));

  // R3: two snapshots back to back, with no event between them, agree
  p_repeat_snapshot_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(latchWr && !tic && chanClrWr == '0 && carrRd == '0 && !flushC)
     && $past(carrRd, 2) == '0 && latchWr && !flushC)
    |=> ($stable(statusA) && $stable(statusB)));

  generate
    for (genvar g = 0; g < MSL_CH; g++) begin : g_chan
      // R5: a snapshot taken just after a clear write shows the channel empty
      p_clear_then_snap_r5: assert property (@(posedge clk) disable iff (!rstN)
        ($past(chanClrWr[g]) && latchWr && !flushC)
        |=> (!statusA[g] && !statusB[g] && !statusB[MSL_SLEW_BASE+g]));
    end
  endgenerate
endmodule

bind msl_status_latch msl_status_latch_chk u_chk (.*);

// File: tb/msl_status_latch_test.sv
module msl_status_latch_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0, swReset = 1'b0, phaseEn = 1'b1;
  logic        intOut = 1'b0, intIn = 1'b0, latchWr = 1'b0, tic = 1'b0;
  logic [5:0]  chanClrWr = '0, carrRd = '0, dataRdy = '0, slewIn = '0;
  logic [15:0] statusA, statusB;

  msl_status_latch uut (.*);

  int compared = 0, mismatched = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  // Behavioural reference state
  bit [5:0] mNew, mMiss, mSlew, sNew, sMiss, sSlew, pRd;
  bit pIO, pII;

  always @(posedge clk) begin
    if (!rstN) begin
      mNew = 0; mMiss = 0; mSlew = 0; sNew = 0; sMiss = 0; sSlew = 0;
      pRd = 0; pIO = 0; pII = 0;
    end else begin
      bit [5:0] oNew, oMiss, oSlew, oSNew;
      bit trig;
      oNew = mNew; oMiss = mMiss; oSlew = mSlew; oSNew = sNew;
      trig = (intOut && !pIO) || (intIn && !pII) || latchWr;
      if (swReset || !phaseEn) begin
        mNew = 0; mMiss = 0; mSlew = 0; sNew = 0; sMiss = 0; sSlew = 0;
      end else begin
        if (trig) begin sNew = oNew; sMiss = oMiss; sSlew = oSlew; end
        for (int i = 0; i < 6; i++) begin
          if (chanClrWr[i]) begin
            mNew[i] = 0; mMiss[i] = 0; mSlew[i] = 0;
          end else begin
            if (tic && dataRdy[i] && !oNew[i]) mNew[i] = 1;
            else if (pRd[i] && !carrRd[i] && oSNew[i]) mNew[i] = 0;
            if (tic && dataRdy[i] && oNew[i]) mMiss[i] = 1;
            if (tic && !oNew[i]) mSlew[i] = slewIn[i];
          end
        end
      end
      pIO = intOut; pII = intIn; pRd = carrRd;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      logic [15:0] eA, eB;
      eA = {10'b0, sNew};
      eB = {2'b0, sSlew, 2'b0, sMiss};
      compared++;
      if (statusA !== eA || statusB !== eB) begin
        mismatched++;
        $display("FAIL %s at %0t: statusA=%h statusB=%h expected %h %h",
                 curReq, $time, statusA, statusB, eA, eB);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doTic(logic [5:0] rdy, logic [5:0] sl);
    tic = 1; dataRdy = rdy; slewIn = sl; step();
    tic = 0; dataRdy = 0; slewIn = 0; step();
  endtask

  task automatic doLatch();
    latchWr = 1; step(); latchWr = 0; step();
  endtask

  task automatic doRead(logic [5:0] m);
    carrRd = m; step(); carrRd = 0; step();
  endtask

  task automatic doClr(logic [5:0] m);
    chanClrWr = m; step(); chanClrWr = 0; step();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    curReq = "R1"; step(3); rstN = 1; step(3);
    curReq = "R4"; doTic(6'b000101, 6'b000001); doLatch();
    curReq = "R2"; step(2);
    curReq = "R7"; doTic(6'b111111, 6'b111110); doLatch();
    curReq = "R8"; doTic(6'b000000, 6'b111111); doLatch();
    curReq = "R6"; doRead(6'b000011); doLatch();
    doClr(6'b111111); doLatch();
    doTic(6'b111111, 6'b000000);
    doRead(6'b111111); doLatch();   // data came after the snapshot: still set
    doRead(6'b000100); doLatch();   // now the snapshot shows it: released
    curReq = "R5";
    chanClrWr = 6'b001001; tic = 1; dataRdy = 6'b111111; slewIn = 6'b111111; step();
    chanClrWr = 0; tic = 0; dataRdy = 0; slewIn = 0; step();
    doLatch();
    curReq = "R3";
    doTic(6'b001001, 6'b001000);
    intOut = 1; step(4); intOut = 0; step(2);
    doClr(6'b000001);
    intIn = 1; step(3);
    doTic(6'b000001, 6'b000000);
    intIn = 0; step(); intIn = 1; step(); intIn = 0; step(2);
    carrRd = 6'b000001; tic = 1; dataRdy = 6'b000001; step();
    carrRd = 0; tic = 0; dataRdy = 0; step(); doLatch();
    curReq = "R9";
    swReset = 1; step(); swReset = 0; step(2);
    doTic(6'b111111, 6'b010101); doLatch();
    phaseEn = 0; step(2); phaseEn = 1; step(2);
    doTic(6'b110000, 6'b110000); doTic(6'b110000, 6'b0); doLatch();
    rstN = 0; step(2);
    curReq = "R1"; rstN = 1; step(3);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule